// File: doc/BRIEF.md
# Double-Buffered Crosspoint Switch Matrix

This block is a non-blocking single-bit crosspoint switch. By default it has 32 data inputs and 32 data outputs. Each output is driven by its own multiplexer, and that multiplexer can pick any input, so one input may feed any number of outputs. The data path is purely combinational. A change on an input reaches every output that selects it within the same cycle.

The selection for each output is held in two register stages: a staging (program) register and an active (configuration) register.

- A host writes staging registers one output at a time. It places a source port number on the source address and a destination port number on the destination address, then raises the write strobe.
- Staging writes have no effect on the live paths.
- The commit strobe copies every staging register into its active register on the same clock edge. Outputs whose selection is unchanged keep passing data without a break.
- The map-reset strobe loads a fixed mapping into both register stages at once. If the commit level is low during map-reset, every output takes input 0 (broadcast). If the commit level is high, output i takes input i (straight-through).

All strobes are sampled on rising clock edges. A strobe held high acts on every cycle it is high.

Top module: `xbar_matrix`

## Requirements
- R1: A cycle with map_reset high and commit low makes every output follow data_in[0] from the next cycle on. wr_en is held low whenever map_reset is high.
- R2: A cycle with map_reset high and commit high makes data_out[i] follow data_in[i] for every i from the next cycle on.
- R3: A cycle with wr_en high and commit low updates only the staging register of output dst_sel. data_out keeps following the previously active selections.
- R4: A cycle with commit high (map_reset low) makes all outputs switch together to their staged selections on the following cycle.
- R5: When wr_en and commit are high in the same cycle, the value being written is the one committed for output dst_sel in that cycle.
- R6: Any mapping is allowed, including one input driving many outputs. data_out[j] equals data_in[sel_j] combinationally, in the same cycle that data_in changes.
- R7: On a commit, an output whose staged selection equals its active selection continues to follow the same input, with no cycle of different data.
- R8: Map-reset overwrites the staging registers as well. A commit with no write after a map-reset keeps the reset mapping, and writes staged before the map-reset are discarded.
- R9: Port addresses are plain binary: value k on src_sel names input k and on dst_sel names output k. 0 is port 0 and all-ones (31) is port 31.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge active |
| wr_en | input | 1 | Staging write strobe |
| commit | input | 1 | Commit strobe; during map_reset it also chooses the mapping (0 broadcast, 1 straight-through) |
| map_reset | input | 1 | Loads a fixed mapping into both register stages |
| src_sel | input | SEL_W (5) | Source input port number to write |
| dst_sel | input | SEL_W (5) | Destination output port whose staging register is written |
| data_in | input | N_PORTS (32) | Data inputs, bit i is input port i |
| data_out | output | N_PORTS (32) | Data outputs, bit j is output port j |

## Verification
The assertions assume that wr_en is low in any cycle where map_reset is high. They also assume that nothing is checked until a first map_reset has been sampled, since the register stages have no defined value before then. The stimulus starts with a map-reset and only writes in cycles without one. All later traffic is built from write, commit and map-reset cycles whose combinations respect that rule, including a run of random write and commit cycles with map_reset held low.

// File: rtl/xbar_pkg.sv
package xbar_pkg;

   // Width of a port number for a switch of n ports.
   function automatic int unsigned port_sel_width(input int unsigned n);
      return (n <= 1) ? 1 : $clog2(n);
   endfunction

   // Choice of multiplexer implementation per output.
   typedef enum logic [0:0] {
      MUX_INDEXED = 1'b0,
      MUX_AND_OR  = 1'b1
   } mux_style_e;

endpackage

// File: rtl/xbar_stage_bank.sv
module xbar_stage_bank #(
   parameter int unsigned N_PORTS = 32,
   parameter int unsigned SEL_W   = 5
) (
   input  logic                       clk,
   input  logic                       map_reset,
   input  logic                       map_identity,
   input  logic                       wr_en,
   input  logic [SEL_W-1:0]           src_sel,
   input  logic [SEL_W-1:0]           dst_sel,
   output logic [N_PORTS*SEL_W-1:0]   stage_flat
);

   for (genvar j = 0; j < N_PORTS; j++) begin : g_stage
      logic [SEL_W-1:0] stage_q;

      always_ff @(posedge clk) begin
         if (map_reset) begin
            stage_q <= map_identity ? SEL_W'(j) : '0;
         end else if (wr_en && (dst_sel == SEL_W'(j))) begin
            stage_q <= src_sel;
         end
      end

      assign stage_flat[j*SEL_W +: SEL_W] = stage_q;
   end

endmodule

// File: rtl/xbar_active_bank.sv
module xbar_active_bank #(
   parameter int unsigned N_PORTS = 32,
   parameter int unsigned SEL_W   = 5
) (
   input  logic                       clk,
   input  logic                       map_reset,
   input  logic                       map_identity,
   input  logic                       commit,
   input  logic                       wr_en,
   input  logic [SEL_W-1:0]           src_sel,
   input  logic [SEL_W-1:0]           dst_sel,
   input  logic [N_PORTS*SEL_W-1:0]   stage_flat,
   output logic [N_PORTS*SEL_W-1:0]   act_flat
);

   for (genvar j = 0; j < N_PORTS; j++) begin : g_active
      logic [SEL_W-1:0] act_q;
      logic [SEL_W-1:0] next_sel;
      logic             wr_hit;

      // A write in the commit cycle bypasses the staging register.
      assign wr_hit   = wr_en && (dst_sel == SEL_W'(j));
      assign next_sel = wr_hit ? src_sel : stage_flat[j*SEL_W +: SEL_W];

      always_ff @(posedge clk) begin
         if (map_reset) begin
            act_q <= map_identity ? SEL_W'(j) : '0;
         end else if (commit) begin
            act_q <= next_sel;
         end
      end

      assign act_flat[j*SEL_W +: SEL_W] = act_q;
   end

endmodule

// File: rtl/xbar_out_mux.sv
module xbar_out_mux #(
   parameter int unsigned        N_PORTS = 32,
   parameter int unsigned        SEL_W   = 5,
   parameter xbar_pkg::mux_style_e STYLE = xbar_pkg::MUX_INDEXED
) (
   input  logic [N_PORTS-1:0] data_in,
   input  logic [SEL_W-1:0]   sel,
   output logic               data_out
);

   if (STYLE == xbar_pkg::MUX_AND_OR) begin : g_andor
      logic [N_PORTS-1:0] hot;
      for (genvar i = 0; i < N_PORTS; i++) begin : g_dec
         assign hot[i] = (sel == SEL_W'(i));
      end
      assign data_out = |(hot & data_in);
   end else begin : g_indexed
      always_comb begin
         if (int'(sel) < int'(N_PORTS)) begin
            data_out = data_in[sel];
         end else begin
            data_out = 1'b0;
         end
      end
   end

endmodule

// File: rtl/xbar_matrix.sv
module xbar_matrix #(
   parameter int unsigned          N_PORTS = 32,
   parameter xbar_pkg::mux_style_e MUX_STYLE = xbar_pkg::MUX_INDEXED,
   parameter int unsigned          SEL_W = xbar_pkg::port_sel_width(N_PORTS)
) (
   input  logic               clk,
   input  logic               wr_en,
   input  logic               commit,
   input  logic               map_reset,
   input  logic [SEL_W-1:0]   src_sel,
   input  logic [SEL_W-1:0]   dst_sel,
   input  logic [N_PORTS-1:0] data_in,
   output logic [N_PORTS-1:0] data_out
);

   localparam int unsigned FLAT_W = N_PORTS * SEL_W;

   if (N_PORTS < 2) begin : g_bad_ports
      $error("xbar_matrix: N_PORTS must be at least 2");
   end
   if ((2 ** SEL_W) < N_PORTS) begin : g_bad_sel
      $error("xbar_matrix: SEL_W too narrow for N_PORTS");
   end

   logic [FLAT_W-1:0] stage_flat;
   logic [FLAT_W-1:0] act_flat;

   // During map_reset the commit level picks straight-through.
   logic map_identity;
   assign map_identity = commit;

   xbar_stage_bank #(
      .N_PORTS (N_PORTS),
      .SEL_W   (SEL_W)
   ) u_stage (
      .clk          (clk),
      .map_reset    (map_reset),
      .map_identity (map_identity),
      .wr_en        (wr_en),
      .src_sel      (src_sel),
      .dst_sel      (dst_sel),
      .stage_flat   (stage_flat)
   );

   xbar_active_bank #(
      .N_PORTS (N_PORTS),
      .SEL_W   (SEL_W)
   ) u_active (
      .clk          (clk),
      .map_reset    (map_reset),
      .map_identity (map_identity),
      .commit       (commit),
      .wr_en        (wr_en),
      .src_sel      (src_sel),
      .dst_sel      (dst_sel),
      .stage_flat   (stage_flat),
      .act_flat     (act_flat)
   );

   for (genvar j = 0; j < N_PORTS; j++) begin : g_out
      xbar_out_mux #(
         .N_PORTS (N_PORTS),
         .SEL_W   (SEL_W),
         .STYLE   (MUX_STYLE)
      ) u_mux (
         .data_in  (data_in),
         .sel      (act_flat[j*SEL_W +: SEL_W]),
         .data_out (data_out[j])
      );
   end

endmodule

// File: rtl/xbar_matrix_chk.sv
module xbar_matrix_chk #(
   parameter int unsigned N_PORTS = 32,
   parameter int unsigned SEL_W   = 5
) (
   input logic                     clk,
   input logic                     wr_en,
   input logic                     commit,
   input logic                     map_reset,
   input logic [SEL_W-1:0]         src_sel,
   input logic [SEL_W-1:0]         dst_sel,
   input logic [N_PORTS-1:0]       data_in,
   input logic [N_PORTS-1:0]       data_out,
   input logic [N_PORTS*SEL_W-1:0] act_flat
);

   // Register stages are defined only after the first sampled map_reset.
   logic armed = 1'b0;
   always_ff @(posedge clk) begin
      if (map_reset) armed <= 1'b1;
   end

   p_no_load_in_reset_r1: assert property (@(posedge clk) disable iff (!armed)
      map_reset |-> !wr_en);

   p_broadcast_r1: assert property (@(posedge clk) disable iff (!armed)
      (map_reset && !commit) |=> (data_out == {N_PORTS{data_in[0]}}));

   p_passthru_r2: assert property (@(posedge clk) disable iff (!armed)
      (map_reset && commit) |=> (data_out == data_in));

   p_stage_only_r3: assert property (@(posedge clk) disable iff (!armed)
      (!commit && !map_reset) |=> $stable(act_flat));

   p_merge_r5: assert property (@(posedge clk) disable iff (!armed)
      (wr_en && commit && !map_reset && (int'(dst_sel) < int'(N_PORTS)))
      |=> (act_flat[$past(dst_sel)*SEL_W +: SEL_W] == $past(src_sel)));

   p_reset_staged_r8: assert property (@(posedge clk) disable iff (!armed)
      (commit && !wr_en && !map_reset && $past(map_reset) && !$past(commit))
      |=> (data_out == {N_PORTS{data_in[0]}}));

endmodule

bind xbar_matrix xbar_matrix_chk #(
   .N_PORTS (N_PORTS),
   .SEL_W   (SEL_W)
) u_chk (.*);

// File: tb/test_xbar_matrix.sv
module test_xbar_matrix;

   localparam int N  = 32;
   localparam int SW = 5;

   logic          clk = 1'b0;
   logic          wr_en = 1'b0;
   logic          commit = 1'b0;
   logic          map_reset = 1'b0;
   logic [SW-1:0] src_sel = '0;
   logic [SW-1:0] dst_sel = '0;
   logic [N-1:0]  data_in = '0;
   logic [N-1:0]  data_out;

   always #10 clk = ~clk;

   xbar_matrix #(.N_PORTS(N)) i_xbar_matrix (
      .clk       (clk),
      .wr_en     (wr_en),
      .commit    (commit),
      .map_reset (map_reset),
      .src_sel   (src_sel),
      .dst_sel   (dst_sel),
      .data_in   (data_in),
      .data_out  (data_out)
   );

   int act_m  [N];
   int prog_m [N];
   bit model_ok = 1'b0;
   bit done = 1'b0;
   int checks = 0;
   int errors = 0;

   function automatic logic [N-1:0] expect_out(input logic [N-1:0] din);
      logic [N-1:0] r;
      for (int j = 0; j < N; j++) r[j] = din[act_m[j]];
      return r;
   endfunction

   task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s data_out=%h expected=%h", tag, act, exp);
      end
   endtask

   // One cycle: drive at negedge, check combinational path, update model at posedge, check result.
   task automatic cyc(input logic l, input logic c, input logic r,
                      input int ia, input int oa, input string tag);
      wr_en     = l;
      commit    = c;
      map_reset = r;
      src_sel   = SW'(ia);
      dst_sel   = SW'(oa);
      data_in   = $urandom;
      #1;
      if (model_ok) check(tag, data_out, expect_out(data_in));
      @(posedge clk);
      if (r) begin
         for (int j = 0; j < N; j++) begin
            act_m[j]  = c ? j : 0;
            prog_m[j] = c ? j : 0;
         end
         model_ok = 1'b1;
      end else begin
         if (l) prog_m[oa] = ia;
         if (c) for (int j = 0; j < N; j++) act_m[j] = prog_m[j];
      end
      @(negedge clk);
      if (model_ok) check(tag, data_out, expect_out(data_in));
   endtask

   initial begin
      @(negedge clk);
      // R1: broadcast map-reset
      cyc(0, 0, 1, 0, 0, "R1");
      repeat (3) cyc(0, 0, 0, 0, 0, "R1");
      // R3 and R9: staging writes, boundary addresses
      cyc(1, 0, 0, 17, 5, "R3");
      cyc(1, 0, 0, 31, 31, "R9");
      cyc(1, 0, 0, 1, 0, "R9");
      cyc(1, 0, 0, 9, 12, "R3");
      repeat (2) cyc(0, 0, 0, 0, 0, "R3");
      // R4: commit all
      cyc(0, 1, 0, 0, 0, "R4");
      repeat (2) cyc(0, 0, 0, 0, 0, "R4");
      // R7: only output 12 changes
      cyc(1, 0, 0, 4, 12, "R7");
      cyc(0, 1, 0, 0, 0, "R7");
      cyc(0, 0, 0, 0, 0, "R7");
      // R5: write and commit together
      cyc(1, 1, 0, 22, 7, "R5");
      cyc(0, 0, 0, 0, 0, "R5");
      // R3: write strobe held over several cycles
      for (int k = 0; k < 4; k++) cyc(1, 0, 0, k + 2, k + 20, "R3");
      cyc(0, 1, 0, 0, 0, "R4");
      // R2: straight-through map-reset
      cyc(0, 1, 1, 0, 0, "R2");
      repeat (2) cyc(0, 0, 0, 0, 0, "R2");
      // R8: commit without writes keeps the reset mapping
      cyc(0, 1, 0, 0, 0, "R8");
      cyc(0, 0, 0, 0, 0, "R8");
      // R6: fan-out of one input to many outputs
      for (int o = 0; o < N; o++) cyc(1, 0, 0, (o % 4 == 0) ? 30 : 7, o, "R6");
      cyc(0, 1, 0, 0, 0, "R6");
      repeat (3) cyc(0, 0, 0, 0, 0, "R6");
      // R8: pending write discarded by map-reset
      cyc(1, 0, 0, 3, 3, "R8");
      cyc(0, 0, 1, 0, 0, "R1");
      cyc(0, 1, 0, 0, 0, "R8");
      cyc(0, 0, 0, 0, 0, "R8");
      // R6: random writes and commits
      for (int k = 0; k < 200; k++)
         cyc(1'($urandom), 1'(($urandom % 4) == 0), 0, int'($urandom % N), int'($urandom % N), "R6");
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog all requirements actual=timeout expected=completion");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule